// File: doc/BRIEF.md
# Keyword Instruction Macro Expander

This block sits in the instruction fetch path, between program memory and the processor. In normal operation it passes each fetched byte straight through. When a fetched byte matches a keyword in the active keyword set and the block is enabled, it takes over the instruction stream. It then supplies a run of 8-bit codes from an internal link table, one code per fetch, and asserts a hold on the program counter so that memory is not advanced while it injects.

The next injected code is found by looking up the code currently being emitted. That code is kept in a feedback register and decoded against the table, under the keyword set that was latched at the start. A lookup that yields all ones, or that finds no entry, ends the expansion, and the following fetch is served from memory again. Two enable inputs form a set index, so the same keyword byte can expand into different bodies or not expand at all. This allows diagnostics or macros to be switched on by condition.

Top module: `kmx_expander`

## Requirements
- R1: A synchronous active-low reset puts the block in pass-through: `inject_sel`=0, `pc_hold`=0, `instr_out`=`mem_data`. This also holds when reset arrives in the middle of an expansion.
- R2: In pass-through, `instr_out` follows `mem_data` combinationally and both `pc_hold` and `inject_sel` are 0.
- R3: An expansion starts only on a fetch (`fetch_stb`=1) where `chip_en`=1, the set index {`set_en_b`,`set_en_a`} is nonzero and `mem_data` is a keyword of that set. The keyword byte itself is delivered from memory in that same fetch, and injection begins with the next fetch.
- R4: While expanding, `inject_sel`=1, `pc_hold`=1 and `instr_out` equals the code held in the feedback register. That code changes only on a cycle with `fetch_stb`=1.
- R5: On each fetch during an expansion, the next code is the table successor of the current code within the set latched at the start.
- R6: A successor equal to 8'hFF, or a missing successor, ends the expansion after the fetch of the last code. 8'hFF is never injected, and the next fetch is served from memory.
- R7: Set index 1 (only `set_en_a`), 2 (only `set_en_b`) and 3 (both) choose separate keyword sets. Set index 0 disables expansion. In the default table, 8'hA0 expands to 11,12,13 in set 1 and to 35,36 in set 3. 8'hA1 gives 14 in set 1. 8'hB0 gives 21,22 and 8'hB1 gives 23,24,25,26 in set 2. 8'hC0 gives 31 and 8'hC1 gives 32,33,34 in set 3.
- R8: During an expansion, `mem_data`, `chip_en` and both set enables have no effect on the injected codes. A keyword byte seen then does not restart the expansion.
- R9: A keyword whose first table code is 8'hFF does not start an expansion. In the default table this is 8'hA2 in set 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_stb | input | 1 | One pulse per instruction fetch |
| mem_data | input | 8 | Instruction byte from program memory |
| chip_en | input | 1 | Allows a keyword to start an expansion |
| set_en_a | input | 1 | Low bit of the keyword set index |
| set_en_b | input | 1 | High bit of the keyword set index |
| instr_out | output | 8 | Instruction byte delivered to the processor |
| pc_hold | output | 1 | Holds the program counter while codes are injected |
| inject_sel | output | 1 | 1 = injected code drives the stream, 0 = memory |

## Verification
The hardest case to reach is a keyword byte, or a change of set enables, arriving from memory while an expansion is in progress and the strobe is idle or active. The block must neither restart nor switch tables in that case. Directed sequences start a long expansion and then present another set's keyword with different enables. Random stimulus biases `mem_data` heavily toward keyword values while strobes, enables and `chip_en` vary. This produces many overlaps of that kind, and a bench reference model checks every one.

// File: rtl/kmx_pkg.sv
// Shared types and the default link table for the keyword macro expander.
// Assumes 8-bit instruction codes and a 2-bit keyword set index.
package kmx_pkg;
    localparam int CODE_W = 8;
    localparam int SET_W  = 2;
    localparam logic [CODE_W-1:0] TERM_CODE = '1;

    // One table row: a keyword start (is_key=1) or a chain step (is_key=0).
    typedef struct packed {
        logic              is_key;
        logic [SET_W-1:0]  set_id;
        logic [CODE_W-1:0] src;
        logic [CODE_W-1:0] dst;
    } link_t;

    localparam int DEF_LINKS = 17;

    localparam link_t [DEF_LINKS-1:0] DEF_TABLE = {
        // set 1
        {1'b1, 2'd1, 8'hA0, 8'h11},
        {1'b0, 2'd1, 8'h11, 8'h12},
        {1'b0, 2'd1, 8'h12, 8'h13},
        {1'b1, 2'd1, 8'hA1, 8'h14},
        {1'b1, 2'd1, 8'hA2, 8'hFF},
        // set 2
        {1'b1, 2'd2, 8'hB0, 8'h21},
        {1'b0, 2'd2, 8'h21, 8'h22},
        {1'b1, 2'd2, 8'hB1, 8'h23},
        {1'b0, 2'd2, 8'h23, 8'h24},
        {1'b0, 2'd2, 8'h24, 8'h25},
        {1'b0, 2'd2, 8'h25, 8'h26},
        // set 3
        {1'b1, 2'd3, 8'hC0, 8'h31},
        {1'b1, 2'd3, 8'hC1, 8'h32},
        {1'b0, 2'd3, 8'h32, 8'h33},
        {1'b0, 2'd3, 8'h33, 8'h34},
        {1'b1, 2'd3, 8'hA0, 8'h35},
        {1'b0, 2'd3, 8'h35, 8'h36}
    };
endpackage

// File: rtl/kmx_lookup.sv
// Combinational table lookup: finds the row of the wanted kind (keyword
// or chain step) whose set and source code match. The lowest index wins.
// Assumes the table is a constant parameter. A miss returns the terminator.
module kmx_lookup
    import kmx_pkg::*;
#(
    parameter int N_LINKS = DEF_LINKS,
    parameter link_t [N_LINKS-1:0] LINKS = DEF_TABLE,
    parameter bit WANT_KEY = 1'b1
) (
    input  logic [SET_W-1:0]  set_id,
    input  logic [CODE_W-1:0] code,
    output logic              hit,
    output logic [CODE_W-1:0] dst
);
    logic [N_LINKS-1:0] match;

    // One comparator per table row.
    for (genvar g = 0; g < N_LINKS; g++) begin : g_row
        assign match[g] = (LINKS[g].is_key == WANT_KEY) &&
                          (LINKS[g].set_id == set_id) &&
                          (LINKS[g].src == code);
    end

    // Priority select of the matching row's destination code.
    always_comb begin
        hit = |match;
        dst = TERM_CODE;
        for (int i = N_LINKS - 1; i >= 0; i--) begin
            if (match[i]) dst = LINKS[i].dst;
        end
    end
endmodule

// File: rtl/kmx_seq.sv
// Expansion state: active flag, the feedback register holding the code
// now being injected, and the set latched at the start. Advances only on
// fetch strobes. Assumes arm and lookup inputs are settled before the edge.
module kmx_seq
    import kmx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_stb,
    input  logic              arm_ok,
    input  logic [SET_W-1:0]  set_sel,
    input  logic              key_hit,
    input  logic [CODE_W-1:0] key_dst,
    input  logic              step_hit,
    input  logic [CODE_W-1:0] step_dst,
    output logic              active,
    output logic [CODE_W-1:0] cur_code,
    output logic [SET_W-1:0]  set_q
);
    // Start, step or end the expansion once per fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            cur_code <= '0;
            set_q    <= '0;
        end else if (fetch_stb) begin
            if (!active) begin
                if (arm_ok && key_hit && (key_dst != TERM_CODE)) begin
                    active   <= 1'b1;
                    cur_code <= key_dst;
                    set_q    <= set_sel;
                end
            end else if (!step_hit || (step_dst == TERM_CODE)) begin
                active <= 1'b0;
            end else begin
                cur_code <= step_dst;
            end
        end
    end
endmodule

// File: rtl/kmx_expander.sv
// Top of the keyword macro expander. In pass-through it forwards memory
// bytes. After a keyword it injects table codes and holds the program
// counter until the chain reaches the terminator. Assumes one fetch_stb
// pulse per fetch, with mem_data valid in that cycle.
module kmx_expander
    import kmx_pkg::*;
#(
    parameter int N_LINKS = DEF_LINKS,
    parameter link_t [N_LINKS-1:0] LINKS = DEF_TABLE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_stb,
    input  logic [CODE_W-1:0] mem_data,
    input  logic              chip_en,
    input  logic              set_en_a,
    input  logic              set_en_b,
    output logic [CODE_W-1:0] instr_out,
    output logic              pc_hold,
    output logic              inject_sel
);
    logic [SET_W-1:0]  set_sel;
    logic              arm_ok;
    logic              key_hit, step_hit, active;
    logic [CODE_W-1:0] key_dst, step_dst, cur_code;
    logic [SET_W-1:0]  set_q;

    assign set_sel = {set_en_b, set_en_a};
    assign arm_ok  = chip_en && (set_sel != '0);

    kmx_lookup #(.N_LINKS(N_LINKS), .LINKS(LINKS), .WANT_KEY(1'b1)) key_lu_i (
        .set_id(set_sel), .code(mem_data), .hit(key_hit), .dst(key_dst)
    );

    kmx_lookup #(.N_LINKS(N_LINKS), .LINKS(LINKS), .WANT_KEY(1'b0)) step_lu_i (
        .set_id(set_q), .code(cur_code), .hit(step_hit), .dst(step_dst)
    );

    kmx_seq seq_i (
        .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .arm_ok(arm_ok),
        .set_sel(set_sel), .key_hit(key_hit), .key_dst(key_dst),
        .step_hit(step_hit), .step_dst(step_dst), .active(active),
        .cur_code(cur_code), .set_q(set_q)
    );

    // Stream select between memory and injected code.
    always_comb begin
        inject_sel = active;
        pc_hold    = active;
        instr_out  = active ? cur_code : mem_data;
    end
endmodule

// File: rtl/kmx_expander_chk.sv
// Port-level assertions for kmx_expander, attached with bind.
module kmx_expander_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       fetch_stb,
    input logic [7:0] mem_data,
    input logic       chip_en,
    input logic       set_en_a,
    input logic       set_en_b,
    input logic [7:0] instr_out,
    input logic       pc_hold,
    input logic       inject_sel
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !inject_sel && !pc_hold);

    // R2
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inject_sel |-> instr_out == mem_data);

    // R3
    start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inject_sel) |-> $past(fetch_stb && chip_en && (set_en_a || set_en_b)));

    // R4
    hold_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold == inject_sel);

    // R4
    no_strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inject_sel && !fetch_stb |=> inject_sel && $stable(instr_out));

    // R6
    no_term_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inject_sel |-> instr_out != 8'hFF);
endmodule

bind kmx_expander kmx_expander_chk chk_i (
    .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .mem_data(mem_data),
    .chip_en(chip_en), .set_en_a(set_en_a), .set_en_b(set_en_b),
    .instr_out(instr_out), .pc_hold(pc_hold), .inject_sel(inject_sel)
);

// File: tb/kmx_expander_tb.sv
`timescale 1ns/1ps
module kmx_expander_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fetch_stb = 1'b0;
    logic [7:0] mem_data = 8'h00;
    logic       chip_en = 1'b0, set_en_a = 1'b0, set_en_b = 1'b0;
    logic [7:0] instr_out;
    logic       pc_hold, inject_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    bit       m_act = 0;
    bit [7:0] m_code = 8'h00;
    bit [1:0] m_set = 2'd0;

    always #10 clk = ~clk;

    kmx_expander dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_stb(fetch_stb), .mem_data(mem_data),
        .chip_en(chip_en), .set_en_a(set_en_a), .set_en_b(set_en_b),
        .instr_out(instr_out), .pc_hold(pc_hold), .inject_sel(inject_sel)
    );

    // Expected table from R7/R9: returns {hit, code}.
    function automatic bit [8:0] ref_link(bit key, bit [1:0] s, bit [7:0] c);
        case ({key, s, c})
            {1'b1, 2'd1, 8'hA0}: return {1'b1, 8'h11};
            {1'b0, 2'd1, 8'h11}: return {1'b1, 8'h12};
            {1'b0, 2'd1, 8'h12}: return {1'b1, 8'h13};
            {1'b1, 2'd1, 8'hA1}: return {1'b1, 8'h14};
            {1'b1, 2'd1, 8'hA2}: return {1'b1, 8'hFF};
            {1'b1, 2'd2, 8'hB0}: return {1'b1, 8'h21};
            {1'b0, 2'd2, 8'h21}: return {1'b1, 8'h22};
            {1'b1, 2'd2, 8'hB1}: return {1'b1, 8'h23};
            {1'b0, 2'd2, 8'h23}: return {1'b1, 8'h24};
            {1'b0, 2'd2, 8'h24}: return {1'b1, 8'h25};
            {1'b0, 2'd2, 8'h25}: return {1'b1, 8'h26};
            {1'b1, 2'd3, 8'hC0}: return {1'b1, 8'h31};
            {1'b1, 2'd3, 8'hC1}: return {1'b1, 8'h32};
            {1'b0, 2'd3, 8'h32}: return {1'b1, 8'h33};
            {1'b0, 2'd3, 8'h33}: return {1'b1, 8'h34};
            {1'b1, 2'd3, 8'hA0}: return {1'b1, 8'h35};
            {1'b0, 2'd3, 8'h35}: return {1'b1, 8'h36};
            default:             return {1'b0, 8'hFF};
        endcase
    endfunction

    // One cycle: drive at negedge, check outputs, advance model at posedge.
    task automatic step(input bit rs, input bit stb, input bit [7:0] d,
                        input bit ce, input bit ea, input bit eb, input string req);
        bit [8:0] r;
        bit [7:0] exp_out;
        @(negedge clk);
        rst_n = rs; fetch_stb = stb; mem_data = d;
        chip_en = ce; set_en_a = ea; set_en_b = eb;
        #1;
        exp_out = m_act ? m_code : d;
        checks++;
        if (instr_out !== exp_out || inject_sel !== m_act || pc_hold !== m_act) begin
            errors++;
            $display("FAIL %s: out=%h sel=%b hold=%b expected out=%h sel=%b hold=%b",
                     req, instr_out, inject_sel, pc_hold, exp_out, m_act, m_act);
        end
        @(posedge clk);
        if (!rs) begin
            m_act = 0; m_code = 8'h00; m_set = 2'd0;
        end else if (stb) begin
            if (!m_act) begin
                r = ref_link(1'b1, {eb, ea}, d);
                if (ce && {eb, ea} != 2'd0 && r[8] && r[7:0] != 8'hFF) begin
                    m_act = 1; m_code = r[7:0]; m_set = {eb, ea};
                end
            end else begin
                r = ref_link(1'b0, m_set, m_code);
                if (!r[8] || r[7:0] == 8'hFF) m_act = 0;
                else m_code = r[7:0];
            end
        end
    endtask

    function automatic bit [7:0] pick_data();
        bit [7:0] kw[7] = '{8'hA0, 8'hA1, 8'hA2, 8'hB0, 8'hB1, 8'hC0, 8'hC1};
        if ($urandom_range(0, 1) == 0) return kw[$urandom_range(0, 6)];
        return 8'($urandom_range(0, 255));
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1 reset state
        step(0, 1, 8'h5A, 1, 1, 0, "R1");
        step(0, 0, 8'hA0, 1, 1, 0, "R1");
        // R2 pass-through
        step(1, 1, 8'h3C, 1, 1, 0, "R2");
        step(1, 0, 8'h77, 0, 0, 0, "R2");
        // R3 start with set 1 keyword, R5 chain, R6 resume
        step(1, 1, 8'hA0, 1, 1, 0, "R3");
        step(1, 1, 8'h00, 1, 1, 0, "R5");
        step(1, 1, 8'h00, 1, 1, 0, "R5");
        step(1, 1, 8'h00, 1, 1, 0, "R5");
        step(1, 1, 8'h42, 1, 1, 0, "R6");
        // R3 chip_en low blocks start; R7 set 0 disables
        step(1, 1, 8'hA1, 0, 1, 0, "R3");
        step(1, 1, 8'hA1, 1, 0, 0, "R7");
        step(1, 0, 8'h10, 1, 0, 0, "R7");
        // R9 keyword whose first code is the terminator
        step(1, 1, 8'hA2, 1, 1, 0, "R9");
        step(1, 0, 8'h55, 1, 1, 0, "R9");
        // R4 no strobe holds the code, set 2 long body
        step(1, 1, 8'hB1, 1, 0, 1, "R3");
        step(1, 0, 8'h99, 1, 0, 1, "R4");
        step(1, 0, 8'h98, 0, 0, 0, "R4");
        step(1, 1, 8'h00, 1, 0, 1, "R5");
        step(1, 1, 8'h00, 1, 0, 1, "R5");
        step(1, 1, 8'h00, 1, 0, 1, "R5");
        step(1, 1, 8'h00, 1, 0, 1, "R6");
        step(1, 0, 8'h01, 1, 0, 1, "R6");
        // R7 same keyword in set 3 gives another body
        step(1, 1, 8'hA0, 1, 1, 1, "R7");
        step(1, 1, 8'hA0, 1, 1, 1, "R7");
        step(1, 1, 8'hA0, 1, 1, 1, "R7");
        step(1, 0, 8'h02, 1, 1, 1, "R7");
        // R8 keyword and enable changes during expansion are ignored
        step(1, 1, 8'hC1, 1, 1, 1, "R8");
        step(1, 1, 8'hB0, 1, 0, 1, "R8");
        step(1, 1, 8'hA0, 0, 1, 0, "R8");
        step(1, 1, 8'hC0, 1, 1, 1, "R8");
        step(1, 0, 8'h03, 1, 1, 1, "R8");
        // R1 reset mid-expansion
        step(1, 1, 8'hB0, 1, 0, 1, "R3");
        step(0, 1, 8'h04, 1, 0, 1, "R1");
        step(1, 0, 8'h05, 1, 0, 1, "R1");
        // constrained random, mostly R5
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 199) != 0, $urandom_range(0, 9) < 7, pick_data(),
                 $urandom_range(0, 9) != 0, 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), "R5");
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule